// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block interprets the write cycles that a host issues to a parallel flash memory. Each write carries an address, a data byte and a flag that selects byte or word addressing. Most commands start with a two-write unlock prefix at fixed coded addresses, followed by a command byte. The decoder recognises return-to-array, signature read, program, block erase and whole-array erase. It also accepts three single-write commands: a reset, a pause of a running erase and a restart of a paused erase.

The decoder drives the read-path mode: normal array data, signature data or operation status. For each operation it starts, it issues a one-clock start pulse and holds the captured address and data for the program and erase engines. The engine reports back through three inputs: a busy level, a flag that marks the running operation as an erase, and a flag for the open erase-timeout window. While an erase is paused, the decoder keeps a per-block record of the blocks being erased. It uses that record to refuse programs into those blocks and to flag reads that fall into them. It also forms the signature byte that a read in signature mode returns.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The unlock prefix is matched on address bits [10:0] only, and bits above 10 are ignored. The first prefix cycle (0xAA) and the command cycle must hit 0x2AA in byte mode or 0x555 in word mode. The second prefix cycle (0x55) must hit 0x555 in byte mode or 0x2AA in word mode.
- R2: `read_mode` encodes 0 = array, 1 = signature, 2 = status. After the prefix, a command byte of 0x90 selects signature mode and 0xF0 selects array mode. The mode is visible in the cycle after the write.
- R3: Prefix, then 0xA0, then a fourth write at any address: this raises `prog_start` for one clock after the fourth write. `cmd_addr` and `cmd_data` then hold that write's address and data, and data 0xF0 counts as program data here.
- R4: Prefix, 0x80, prefix again, then a final write. A final 0x30 at any address pulses `erase_start` with `erase_all`=0 and `cmd_addr` set to that address. A final 0x10 at the command-cycle coded address pulses `erase_start` with `erase_all`=1.
- R5: Any write that breaks a sequence restarts it, sets array mode and produces no pulse.
- R6: A single write of 0xF0 at any address, outside the program-data cycle, sets array mode.
- R7: While `busy` is high, `read_mode` is 2 from the next cycle on, and writes start nothing. The only exceptions are those listed in R8 and R9.
- R8: While `busy`, `erase_active` and `tmo_open` are all high after a block erase, a write of 0x30 pulses `erase_add` with that address in `cmd_addr`.
- R9: While `busy` and `erase_active` are high, a write of 0xB0 pulses `suspend_req` and enters the paused state. While paused and not busy, a single write of 0x30 pulses `resume_req` and leaves the paused state.
- R10: While paused, a program whose address lies in a block being erased produces no `prog_start`. `rd_in_erase` is 1 one cycle after `rd_blk` names such a block. Programs and reads in other blocks behave normally. The block index is address bits [18:15].
- R11: `sig_data` follows `rd_sel`, one cycle later. `rd_sel`=0 gives 0x20, `rd_sel`=1 gives the device code (0xC4 by default), `rd_sel`=2 gives {7'b0, `prot_status[rd_blk]`} and `rd_sel`=3 gives 0x00.
- R12: Every start, add, suspend and resume pulse lasts exactly one clock. A synchronous reset restarts the sequence, clears the paused state and gives array mode with no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write cycle strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| word_mode | input | 1 | 1 = word addressing, 0 = byte addressing |
| busy | input | 1 | Program/erase engine running |
| erase_active | input | 1 | Running operation is an erase |
| tmo_open | input | 1 | Erase timeout window still open |
| rd_sel | input | 2 | Read address bits A1:A0 for signature reads |
| rd_blk | input | BW | Block index of the read address |
| prot_status | input | NBLK | Per-block protection flags |
| read_mode | output | 2 | Read path mode (0 array, 1 signature, 2 status) |
| prog_start | output | 1 | One-clock program start |
| erase_start | output | 1 | One-clock erase start |
| erase_all | output | 1 | Qualifies erase_start as whole-array erase |
| erase_add | output | 1 | One-clock request to queue another block |
| suspend_req | output | 1 | One-clock erase pause request |
| resume_req | output | 1 | One-clock erase restart request |
| cmd_addr | output | AW | Captured address of the last pulse |
| cmd_data | output | 8 | Captured data of the last pulse |
| sig_data | output | 8 | Signature read byte |
| rd_in_erase | output | 1 | Read block is being erased during a pause |

## Verification
The assertions check several properties on every cycle. Pulses stay one clock wide and never overlap. `erase_all` never appears without `erase_start`. A busy engine forces status mode on the next cycle. A pause is only requested while an erase is busy, a restart only while the engine is idle, and a block is only queued while the timeout window was open. The manufacturer-code read path is also checked every cycle. Other properties depend on a full write history, and only the bench's scenarios can show them. These are the exact coded addresses per addressing mode, the masking of upper address bits, and the way broken sequences fall back to array mode. They also include refusing programs into paused-erase blocks, and the fact that 0xF0 is taken as program data in the fourth program cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_SIG    = 2'd1,
    RM_STATUS = 2'd2
  } rmode_t;

  typedef enum logic [2:0] {
    SQ_C1, SQ_C2, SQ_C3, SQ_PD, SQ_E4, SQ_E5, SQ_E6
  } seq_t;

  localparam logic [7:0] K_UNLK_A = 8'hAA;
  localparam logic [7:0] K_UNLK_B = 8'h55;
  localparam logic [7:0] K_RESET  = 8'hF0;
  localparam logic [7:0] K_SIG    = 8'h90;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ESETUP = 8'h80;
  localparam logic [7:0] K_BLK    = 8'h30;
  localparam logic [7:0] K_CHIP   = 8'h10;
  localparam logic [7:0] K_SUSP   = 8'hB0;

  localparam logic [15:0] BYTE_C1 = 16'hAAAA;
  localparam logic [15:0] BYTE_C2 = 16'h5555;
  localparam logic [15:0] WORD_C1 = 16'h5555;
  localparam logic [15:0] WORD_C2 = 16'h2AAA;

endpackage

// File: rtl/flash_unlock_match.sv
module flash_unlock_match
  import flash_cmd_pkg::*;
#(
  parameter int CODE_BITS = 11
) (
  input  logic [CODE_BITS-1:0] code_addr,
  input  logic                 word_mode,
  output logic                 at_c1,
  output logic                 at_c2
);

  localparam logic [CODE_BITS-1:0] BC1 = CODE_BITS'(BYTE_C1);
  localparam logic [CODE_BITS-1:0] BC2 = CODE_BITS'(BYTE_C2);
  localparam logic [CODE_BITS-1:0] WC1 = CODE_BITS'(WORD_C1);
  localparam logic [CODE_BITS-1:0] WC2 = CODE_BITS'(WORD_C2);

  assign at_c1 = (code_addr == (word_mode ? WC1 : BC1));
  assign at_c2 = (code_addr == (word_mode ? WC2 : BC2));

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          at_c1,
  input  logic          at_c2,
  input  logic          blk_locked,
  input  logic          busy,
  input  logic          erase_active,
  input  logic          tmo_open,
  input  logic          blk_erase,
  output rmode_t        base_mode,
  output logic          susp,
  output logic          prog_p,
  output logic          erase_p,
  output logic          all_p,
  output logic          add_p,
  output logic          susp_p,
  output logic          res_p,
  output logic [AW-1:0] cap_addr,
  output logic [7:0]    cap_data
);

  seq_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_C1;
      base_mode <= RM_ARRAY;
      susp      <= 1'b0;
      prog_p    <= 1'b0;
      erase_p   <= 1'b0;
      all_p     <= 1'b0;
      add_p     <= 1'b0;
      susp_p    <= 1'b0;
      res_p     <= 1'b0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else begin
      prog_p  <= 1'b0;
      erase_p <= 1'b0;
      all_p   <= 1'b0;
      add_p   <= 1'b0;
      susp_p  <= 1'b0;
      res_p   <= 1'b0;
      if (wr_en) begin
        if (busy) begin
          // engine running: only pause and block queueing get through
          st <= SQ_C1;
          if (erase_active && !susp && wr_data == K_SUSP) begin
            susp_p    <= 1'b1;
            susp      <= 1'b1;
            base_mode <= RM_ARRAY;
          end else if (erase_active && tmo_open && blk_erase && wr_data == K_BLK) begin
            add_p    <= 1'b1;
            cap_addr <= wr_addr;
            cap_data <= wr_data;
          end
        end else if (st != SQ_PD && wr_data == K_RESET) begin
          st        <= SQ_C1;
          base_mode <= RM_ARRAY;
        end else begin
          // default: sequence broken, back to array reads
          st        <= SQ_C1;
          base_mode <= RM_ARRAY;
          case (st)
            SQ_C1: begin
              if (susp && wr_data == K_BLK) begin
                res_p <= 1'b1;
                susp  <= 1'b0;
              end else if (at_c1 && wr_data == K_UNLK_A) begin
                st        <= SQ_C2;
                base_mode <= base_mode;
              end
            end
            SQ_C2: begin
              if (at_c2 && wr_data == K_UNLK_B) begin
                st        <= SQ_C3;
                base_mode <= base_mode;
              end
            end
            SQ_C3: begin
              if (at_c1 && wr_data == K_SIG) begin
                base_mode <= RM_SIG;
              end else if (at_c1 && wr_data == K_PROG) begin
                st        <= SQ_PD;
                base_mode <= base_mode;
              end else if (at_c1 && wr_data == K_ESETUP && !susp) begin
                st        <= SQ_E4;
                base_mode <= base_mode;
              end
            end
            SQ_PD: begin
              if (!blk_locked) begin
                prog_p   <= 1'b1;
                cap_addr <= wr_addr;
                cap_data <= wr_data;
              end
            end
            SQ_E4: begin
              if (at_c1 && wr_data == K_UNLK_A) begin
                st        <= SQ_E5;
                base_mode <= base_mode;
              end
            end
            SQ_E5: begin
              if (at_c2 && wr_data == K_UNLK_B) begin
                st        <= SQ_E6;
                base_mode <= base_mode;
              end
            end
            SQ_E6: begin
              if (wr_data == K_BLK) begin
                erase_p  <= 1'b1;
                cap_addr <= wr_addr;
                cap_data <= wr_data;
              end else if (wr_data == K_CHIP && at_c1) begin
                erase_p  <= 1'b1;
                all_p    <= 1'b1;
                cap_addr <= wr_addr;
                cap_data <= wr_data;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/flash_sig_read.sv
module flash_sig_read #(
  parameter int         NBLK     = 16,
  parameter int         BW       = 4,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hC4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      rd_sel,
  input  logic [BW-1:0]   rd_blk,
  input  logic [NBLK-1:0] prot_status,
  output logic [7:0]      sig_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q <= '0;
    end else begin
      case (rd_sel)
        2'b00:   sig_q <= MFR_CODE;
        2'b01:   sig_q <= DEV_CODE;
        2'b10:   sig_q <= {7'b0, prot_status[rd_blk]};
        default: sig_q <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         AW        = 19,
  parameter int         CODE_BITS = 11,
  parameter int         NBLK      = 16,
  parameter logic [7:0] MFR_CODE  = 8'h20,
  parameter logic [7:0] DEV_CODE  = 8'hC4,
  localparam int        BW        = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            word_mode,
  input  logic            busy,
  input  logic            erase_active,
  input  logic            tmo_open,
  input  logic [1:0]      rd_sel,
  input  logic [BW-1:0]   rd_blk,
  input  logic [NBLK-1:0] prot_status,
  output logic [1:0]      read_mode,
  output logic            prog_start,
  output logic            erase_start,
  output logic            erase_all,
  output logic            erase_add,
  output logic            suspend_req,
  output logic            resume_req,
  output logic [AW-1:0]   cmd_addr,
  output logic [7:0]      cmd_data,
  output logic [7:0]      sig_data,
  output logic            rd_in_erase
);

  logic            at_c1, at_c2;
  logic            susp, blk_locked;
  logic            busy_q, blk_erase_q, rie_q;
  logic [NBLK-1:0] mask_q;
  logic [BW-1:0]   wr_blk, cap_blk;
  rmode_t          base_mode;

  assign wr_blk     = wr_addr[AW-1 -: BW];
  assign cap_blk    = cmd_addr[AW-1 -: BW];
  assign blk_locked = susp && mask_q[wr_blk];

  flash_unlock_match #(.CODE_BITS(CODE_BITS)) u_match (
    .code_addr (wr_addr[CODE_BITS-1:0]),
    .word_mode (word_mode),
    .at_c1     (at_c1),
    .at_c2     (at_c2)
  );

  flash_seq_fsm #(.AW(AW)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .at_c1        (at_c1),
    .at_c2        (at_c2),
    .blk_locked   (blk_locked),
    .busy         (busy),
    .erase_active (erase_active),
    .tmo_open     (tmo_open),
    .blk_erase    (blk_erase_q),
    .base_mode    (base_mode),
    .susp         (susp),
    .prog_p       (prog_start),
    .erase_p      (erase_start),
    .all_p        (erase_all),
    .add_p        (erase_add),
    .susp_p       (suspend_req),
    .res_p        (resume_req),
    .cap_addr     (cmd_addr),
    .cap_data     (cmd_data)
  );

  flash_sig_read #(
    .NBLK(NBLK), .BW(BW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_sig (
    .clk         (clk),
    .rst         (rst),
    .rd_sel      (rd_sel),
    .rd_blk      (rd_blk),
    .prot_status (prot_status),
    .sig_q       (sig_data)
  );

  // one tracking bit per block, updated from the registered pulses
  for (genvar g = 0; g < NBLK; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)
        mask_q[g] <= 1'b0;
      else if (erase_start)
        mask_q[g] <= erase_all || (cap_blk == BW'(g));
      else if (erase_add && cap_blk == BW'(g))
        mask_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      blk_erase_q <= 1'b0;
      rie_q       <= 1'b0;
    end else begin
      busy_q <= busy;
      rie_q  <= susp && mask_q[rd_blk];
      if (erase_start)
        blk_erase_q <= !erase_all;
    end
  end

  assign read_mode   = busy_q ? RM_STATUS : base_mode;
  assign rd_in_erase = rie_q;

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
  parameter logic [7:0] MFR_CODE = 8'h20
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       erase_active,
  input logic       tmo_open,
  input logic [1:0] rd_sel,
  input logic [1:0] read_mode,
  input logic       prog_start,
  input logic       erase_start,
  input logic       erase_all,
  input logic       erase_add,
  input logic       suspend_req,
  input logic       resume_req,
  input logic [7:0] sig_data
);

  p_pulse_single_r12: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);

  p_erase_single_r12: assert property (@(posedge clk) disable iff (rst)
    erase_start |=> !erase_start);

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $countones({prog_start, erase_start, erase_add, suspend_req, resume_req}) <= 1);

  p_all_qual_r4: assert property (@(posedge clk) disable iff (rst)
    erase_all |-> erase_start);

  p_busy_status_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> read_mode == 2'd2);

  p_busy_nostart_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> !prog_start && !erase_start);

  p_add_window_r8: assert property (@(posedge clk) disable iff (rst)
    erase_add |-> $past(tmo_open) && $past(busy) && $past(erase_active));

  p_suspend_when_r9: assert property (@(posedge clk) disable iff (rst)
    suspend_req |-> $past(busy) && $past(erase_active));

  p_resume_idle_r9: assert property (@(posedge clk) disable iff (rst)
    resume_req |-> !$past(busy));

  p_sig_mfr_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_sel) == 2'b00) |-> sig_data == MFR_CODE);

endmodule

bind flash_cmd_decoder flash_cmd_checker #(.MFR_CODE(MFR_CODE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .erase_active (erase_active),
  .tmo_open     (tmo_open),
  .rd_sel       (rd_sel),
  .read_mode    (read_mode),
  .prog_start   (prog_start),
  .erase_start  (erase_start),
  .erase_all    (erase_all),
  .erase_add    (erase_add),
  .suspend_req  (suspend_req),
  .resume_req   (resume_req),
  .sig_data     (sig_data)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV         = 39;

  // {word, addr(20), data(8), mode(4), flags(4): bit1 prog, bit0 erase}
  localparam logic [39:0] VEC [NV] = '{
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_0AAAA_F0_0_0,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_0AAAA_90_1_0,
    40'h0_12345_F0_0_0,
    40'h1_7D555_AA_0_0, 40'h1_02AAA_55_0_0, 40'h1_05555_90_1_0,
    40'h1_0AAAA_AA_0_0,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_0AAAA_A0_0_0,
    40'h0_41234_5A_0_2,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_0AAAA_80_0_0,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_48000_30_0_1,
    40'h1_05555_AA_0_0, 40'h1_02AAA_55_0_0, 40'h1_05555_80_0_0,
    40'h1_05555_AA_0_0, 40'h1_02AAA_55_0_0, 40'h1_05555_10_0_1,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_0AAAA_80_0_0,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_54_0_0,
    40'h0_0AAAA_30_0_0,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_0AAAA_80_0_0,
    40'h0_0AAAA_AA_0_0, 40'h0_05555_55_0_0, 40'h0_05555_10_0_0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        word_mode = 1'b0;
  logic        busy = 1'b0, erase_active = 1'b0, tmo_open = 1'b0;
  logic [1:0]  rd_sel = 2'b11;
  logic [3:0]  rd_blk = '0;
  logic [15:0] prot_status = '0;
  logic [1:0]  read_mode;
  logic        prog_start, erase_start, erase_all, erase_add, suspend_req, resume_req;
  logic [18:0] cmd_addr;
  logic [7:0]  cmd_data, sig_data;
  logic        rd_in_erase;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .word_mode, .busy, .erase_active,
    .tmo_open, .rd_sel, .rd_blk, .prot_status, .read_mode, .prog_start,
    .erase_start, .erase_all, .erase_add, .suspend_req, .resume_req,
    .cmd_addr, .cmd_data, .sig_data, .rd_in_erase
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one write cycle; returns at the negedge after the sampling edge
  task automatic wr(input logic w, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    word_mode = w; wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prefix(input logic w);
    wr(w, w ? 19'h05555 : 19'h0AAAA, 8'hAA);
    wr(w, w ? 19'h02AAA : 19'h05555, 8'h55);
  endtask

  task automatic cmd3(input logic w, input logic [7:0] d);
    wr(w, w ? 19'h05555 : 19'h0AAAA, d);
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog act=%0d exp<%0d", WD_CYCLES, WD_CYCLES);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R12: reset state
    chk("R12 reset mode", 32'(read_mode), 32'd0);
    chk("R12 reset pulses", 32'({prog_start, erase_start, erase_add, suspend_req, resume_req}), 32'd0);

    // table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][36], VEC[i][34:16], VEC[i][15:8]);
      chk($sformatf("R1/R2/R5/R6 mode row %0d", i), 32'(read_mode), 32'(VEC[i][5:4]));
      chk($sformatf("R3/R4/R5 pulse row %0d", i), 32'({prog_start, erase_start}), 32'(VEC[i][1:0]));
    end

    // R3: program capture, F0 taken as data
    prefix(1'b1); cmd3(1'b1, 8'hA0);
    wr(1'b1, 19'h20F0F, 8'hF0);
    chk("R3 prog pulse", 32'(prog_start), 32'd1);
    chk("R3 addr", 32'(cmd_addr), 32'h20F0F);
    chk("R3 data", 32'(cmd_data), 32'hF0);
    tick();
    chk("R12 prog one clock", 32'(prog_start), 32'd0);

    // R4: whole-array then block erase
    prefix(1'b1); cmd3(1'b1, 8'h80); prefix(1'b1); cmd3(1'b1, 8'h10);
    chk("R4 chip start", 32'({erase_start, erase_all}), 32'h3);
    prefix(1'b0); cmd3(1'b0, 8'h80); prefix(1'b0);
    wr(1'b0, 19'h48000, 8'h30);
    chk("R4 blk start", 32'({erase_start, erase_all}), 32'h2);
    chk("R4 blk addr", 32'(cmd_addr), 32'h48000);

    // R7: busy erase
    busy = 1'b1; erase_active = 1'b1; tmo_open = 1'b1;
    tick();
    chk("R7 status", 32'(read_mode), 32'd2);
    wr(1'b0, 19'h28000, 8'h30);
    chk("R8 add pulse", 32'(erase_add), 32'd1);
    chk("R8 add addr", 32'(cmd_addr), 32'h28000);
    tmo_open = 1'b0;
    wr(1'b0, 19'h30000, 8'h30);
    chk("R8 window closed", 32'(erase_add), 32'd0);
    wr(1'b0, 19'h00000, 8'hF0);
    chk("R7 reset ignored", 32'(read_mode), 32'd2);
    prefix(1'b0); cmd3(1'b0, 8'hA0);
    wr(1'b0, 19'h41234, 8'h77);
    chk("R7 prog ignored", 32'(prog_start), 32'd0);

    // R9: pause
    wr(1'b0, 19'h00000, 8'hB0);
    chk("R9 suspend pulse", 32'(suspend_req), 32'd1);
    busy = 1'b0; erase_active = 1'b0;
    tick(); tick();
    chk("R9 array while paused", 32'(read_mode), 32'd0);

    // R10: blocks 9 and 5 are under erase
    rd_blk = 4'd9; tick();
    chk("R10 rd blk9", 32'(rd_in_erase), 32'd1);
    rd_blk = 4'd2; tick();
    chk("R10 rd blk2", 32'(rd_in_erase), 32'd0);
    rd_blk = 4'd5; tick();
    chk("R10 rd blk5", 32'(rd_in_erase), 32'd1);
    prefix(1'b0); cmd3(1'b0, 8'hA0);
    wr(1'b0, 19'h48010, 8'h11);
    chk("R10 locked prog", 32'(prog_start), 32'd0);
    prefix(1'b0); cmd3(1'b0, 8'hA0);
    wr(1'b0, 19'h10010, 8'h22);
    chk("R10 free prog", 32'(prog_start), 32'd1);
    chk("R10 free data", 32'(cmd_data), 32'h22);

    // R9: restart
    wr(1'b0, 19'h00000, 8'h30);
    chk("R9 resume pulse", 32'(resume_req), 32'd1);
    rd_blk = 4'd9; tick(); tick();
    chk("R10 unpaused rd", 32'(rd_in_erase), 32'd0);
    busy = 1'b1; erase_active = 1'b1;
    tick(); tick();
    chk("R7 status again", 32'(read_mode), 32'd2);
    busy = 1'b0; erase_active = 1'b0;
    tick(); tick();
    chk("R7 back to array", 32'(read_mode), 32'd0);

    // R11: signature bytes
    prot_status = 16'h0008;
    rd_sel = 2'b00; tick();
    chk("R11 mfr", 32'(sig_data), 32'h20);
    rd_sel = 2'b01; tick();
    chk("R11 dev", 32'(sig_data), 32'hC4);
    rd_sel = 2'b10; rd_blk = 4'd3; tick();
    chk("R11 prot blk3", 32'(sig_data), 32'h01);
    rd_blk = 4'd4; tick();
    chk("R11 prot blk4", 32'(sig_data), 32'h00);
    rd_sel = 2'b11; tick();
    chk("R11 sel3", 32'(sig_data), 32'h00);

    // R12: reset in the middle of a sequence
    prefix(1'b0);
    rst = 1'b1; tick(); rst = 1'b0;
    cmd3(1'b0, 8'hA0);
    wr(1'b0, 19'h41234, 8'h66);
    chk("R12 reset mid seq", 32'(prog_start), 32'd0);
    chk("R12 mode after reset", 32'(read_mode), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule